// File: doc/BRIEF.md
# Dual-Pixel Display Timing Generator

This block produces the raster timing for a 1920x1080 flat panel that accepts two pixels on every clock and relies only on the data-enable strobe to find active video. It runs horizontal and vertical counters, drives a data-enable output, and gives a downstream pattern source the index of the current pixel pair and the current line. A one-clock frame-start marker flags the first clock of every frame.

The line length and frame height are runtime inputs. They are taken into the counters only at a frame boundary, and they are forced into the legal range first: line totals become even and stay between the configured bounds, and frame totals stay between their own bounds. Sync pulses can be generated for sinks that want them, or tied low by a build parameter, since the panel ignores them. A separate brightness-control reference runs at three times the frame rate with half duty. Its phase restarts at every frame start, so it stays locked to the raster.

Top module: `dual_pixel_timing_gen`

## Requirements
- R1: While reset is held, de, hsync, vsync, frame_start, pwm_out, x_pair and y_line are all 0. The first clock after reset is released is the first clock of a frame, with frame_start at 1.
- R2: de is 1 exactly on clocks whose pair index is below H_ACTIVE and whose line index is below V_ACTIVE, and 0 on every other clock.
- R3: While de is 1, x_pair equals the clock's position in the line and y_line equals the line number, both counted from 0. While de is 0, both outputs are 0.
- R4: frame_start is 1 for exactly one clock, the first clock of line 0. Consecutive frame starts are separated by line total times frame total clocks.
- R5: A new line or frame total presented mid-frame does not affect the frame in progress. It takes effect from the next frame start.
- R6: The line total in use is the requested value limited to [H_TOTAL_MIN, H_TOTAL_MAX] and then rounded down to an even number.
- R7: The frame total in use is the requested value limited to [V_TOTAL_MIN, V_TOTAL_MAX].
- R8: With SYNC_EN=1, hsync is 1 on line positions H_ACTIVE+H_FP up to, but not including, H_ACTIVE+H_FP+H_SW. vsync is 1 on whole lines V_ACTIVE+V_FP up to, but not including, V_ACTIVE+V_FP+V_SW.
- R9: With SYNC_EN=0, hsync and vsync stay 0, while de and the coordinates behave exactly as with sync enabled.
- R10: Let F be the frame length in clocks and P = floor(F/3). pwm_out is 1 for the first floor(P/2) clocks of each of three periods per frame. The first two periods are P clocks long. The third period absorbs the remainder and ends at the next frame start. This gives three rising edges per frame.
- R11: pwm_out is 1 on every clock where frame_start is 1, so its phase restarts with each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_total_in | input | TOT_W | Requested line total in pair clocks |
| v_total_in | input | TOT_W | Requested frame total in lines |
| de | output | 1 | Data enable, high during active pairs |
| hsync | output | 1 | Optional horizontal sync pulse |
| vsync | output | 1 | Optional vertical sync pulse |
| x_pair | output | $clog2(H_ACTIVE) | Pixel-pair index within the active line |
| y_line | output | $clog2(V_ACTIVE) | Active line index |
| frame_start | output | 1 | One-clock marker on the first clock of a frame |
| pwm_out | output | 1 | Half-duty reference at three times the frame rate |

## Verification
The bench changes the requested totals in the middle of a frame. A design that applied them at once would produce a frame of the wrong length, and the scan would see frame_start early or late. Odd, too small and too large requests are each sent. A design that failed to clear the low bit or to limit the value would give a frame length different from the expected product. It tests a frame length that is not divisible by three, where a design that let the remainder start a fourth pulse would show a fourth rising edge of pwm_out or a mismatched clock. A second instance built without sync must hold both sync lines low while its data enable matches the first instance clock for clock.

// File: rtl/dpt_pkg.sv
// Shared helpers for the dual-pixel timing generator.
// Assumes callers pass bounds with lo <= hi; when make_even is set,
// lo must be even so rounding down cannot leave the legal window.
package dpt_pkg;

    // Limit a requested total to [lo, hi], optionally rounding down to even.
    function automatic int clamp_total(input int val, input int lo, input int hi,
                                       input bit make_even);
        int r;
        r = val;
        if (r < lo) r = lo;
        if (r > hi) r = hi;
        if (make_even) r = r & ~1;
        return r;
    endfunction

endpackage

// File: rtl/dpt_total_latch.sv
// Holds the line and frame totals used by the counters.
// The requested values are made legal (range-limited, line total even)
// and captured during reset and on the last clock of each frame only.
// Assumes H_TOTAL_MIN is even and every bound fits HW / VW bits.
module dpt_total_latch #(
    parameter int TOT_W       = 12,
    parameter int H_TOTAL_MIN = 1024,
    parameter int H_TOTAL_MAX = 1120,
    parameter int V_TOTAL_MIN = 1090,
    parameter int V_TOTAL_MAX = 1220,
    parameter int HW          = 11,
    parameter int VW          = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TOT_W-1:0] h_req,
    input  logic [TOT_W-1:0] v_req,
    output logic [HW-1:0]    h_tot,
    output logic [VW-1:0]    v_tot
);
    import dpt_pkg::*;

    localparam logic [HW-1:0] H_LO = HW'(H_TOTAL_MIN);
    localparam logic [HW-1:0] H_HI = HW'(H_TOTAL_MAX);
    localparam logic [VW-1:0] V_LO = VW'(V_TOTAL_MIN);
    localparam logic [VW-1:0] V_HI = VW'(V_TOTAL_MAX);

    logic [HW-1:0] h_legal;
    logic [VW-1:0] v_legal;

    // Legalise the requests every cycle; they are used only when captured.
    always_comb begin
        h_legal = HW'(clamp_total(int'(h_req), H_TOTAL_MIN, H_TOTAL_MAX, 1'b1));
        v_legal = VW'(clamp_total(int'(v_req), V_TOTAL_MIN, V_TOTAL_MAX, 1'b0));
    end

    // Capture the legal totals in reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            h_tot <= h_legal;
            v_tot <= v_legal;
        end
    end

    // R6: the line total in use is always even and inside its window.
    assert_h_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_tot[0] == 1'b0) && (h_tot >= H_LO) && (h_tot <= H_HI));

    // R7: the frame total in use stays inside its window.
    assert_v_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_tot >= V_LO) && (v_tot <= V_HI));

    // R5: totals never move except at a frame boundary.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(h_tot) && $stable(v_tot)));

endmodule

// File: rtl/dpt_raster.sv
// Raster counters and decode for a two-pixels-per-clock panel.
// Counts pair positions per line and lines per frame against the
// latched totals, and decodes data enable, coordinates, frame start
// and the optional sync pulses. A run flag keeps every output low in
// reset; the first clock after reset is position (0,0).
// Assumes totals exceed the active sizes plus the sync windows.
module dpt_raster #(
    parameter int H_ACTIVE = 960,
    parameter int V_ACTIVE = 1080,
    parameter int HW       = 11,
    parameter int VW       = 11,
    parameter int XW       = 10,
    parameter int YW       = 11,
    parameter bit SYNC_EN  = 1'b1,
    parameter int H_FP     = 16,
    parameter int H_SW     = 16,
    parameter int V_FP     = 2,
    parameter int V_SW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_tot,
    input  logic [VW-1:0] v_tot,
    output logic          run,
    output logic          frame_end,
    output logic          frame_start,
    output logic          de,
    output logic [XW-1:0] x_pair,
    output logic [YW-1:0] y_line,
    output logic          hsync,
    output logic          vsync
);
    localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
    localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FP + H_SW);
    localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FP + V_SW);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          line_end;

    // Detect the last pair of a line and the last clock of a frame.
    always_comb begin
        line_end  = run && (h_cnt == h_tot - HW'(1));
        frame_end = line_end && (v_cnt == v_tot - VW'(1));
    end

    // Advance the pair and line counters once running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (!run) begin
            run <= 1'b1;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= frame_end ? '0 : v_cnt + VW'(1);
        end else begin
            h_cnt <= h_cnt + HW'(1);
        end
    end

    // Decode active window, coordinates and frame start.
    always_comb begin
        de          = run && (h_cnt < H_ACT) && (v_cnt < V_ACT);
        frame_start = run && (h_cnt == '0) && (v_cnt == '0);
        x_pair      = de ? h_cnt[XW-1:0] : '0;
        y_line      = de ? v_cnt[YW-1:0] : '0;
    end

    generate
        if (SYNC_EN) begin : g_sync
            // Decode sync windows from the counters.
            always_comb begin
                hsync = run && (h_cnt >= HS_BEG) && (h_cnt < HS_END);
                vsync = run && (v_cnt >= VS_BEG) && (v_cnt < VS_END);
            end
        end else begin : g_nosync
            // Panel works from data enable alone: syncs stay idle.
            always_comb begin
                hsync = 1'b0;
                vsync = 1'b0;
            end
        end
    endgenerate

    // R4: the pair counter never reaches the line total.
    assert_h_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (h_cnt < h_tot));

    // R4: the line counter never reaches the frame total.
    assert_v_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (v_cnt < v_tot));

    // R4: frame start lasts a single clock.
    assert_fs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R2: the first clock of a frame is an active pair.
    assert_fs_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> de);

endmodule

// File: rtl/dpt_pwm_ref.sv
// Half-duty reference at three times the frame rate.
// Period P is one third of the frame length in clocks, rounded down;
// the third period stretches to the frame end to absorb the remainder.
// The phase restarts on the clock that follows each frame end.
// Assumes the frame length is at least 3 clocks.
module dpt_pwm_ref #(
    parameter int HW = 11,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          frame_end,
    input  logic [HW-1:0] h_tot,
    input  logic [VW-1:0] v_tot,
    output logic          pwm
);
    localparam int FW = HW + VW;

    logic [FW-1:0] frame_len;
    logic [FW-1:0] period;
    logic [FW-1:0] half;
    logic [FW-1:0] p_cnt;
    logic [1:0]    third;

    // Derive period and high time from the totals in use.
    always_comb begin
        frame_len = FW'(h_tot) * FW'(v_tot);
        period    = frame_len / FW'(3);
        half      = period >> 1;
        pwm       = run && (p_cnt < half);
    end

    // Step the phase counter; the last third runs until frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || frame_end) begin
            p_cnt <= '0;
            third <= 2'd0;
        end else if ((third != 2'd2) && (p_cnt == period - FW'(1))) begin
            p_cnt <= '0;
            third <= third + 2'd1;
        end else begin
            p_cnt <= p_cnt + FW'(1);
        end
    end

    // R10: no fourth period is ever started within a frame.
    assert_third_R10: assert property (@(posedge clk) disable iff (!rst_n)
        third != 2'd3);

    // R10: in the first two thirds the counter stays below one period.
    assert_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (third != 2'd2) |-> (p_cnt < period));

endmodule

// File: rtl/dual_pixel_timing_gen.sv
// Top of the dual-pixel display timing generator.
// Connects the total latch, the raster counters and the frame-locked
// reference generator. Totals are sampled at frame boundaries only.
// Assumes bounds and sync windows are consistent (see submodules).
module dual_pixel_timing_gen #(
    parameter int TOT_W       = 12,
    parameter int H_ACTIVE    = 960,
    parameter int V_ACTIVE    = 1080,
    parameter int H_TOTAL_MIN = 1024,
    parameter int H_TOTAL_MAX = 1120,
    parameter int V_TOTAL_MIN = 1090,
    parameter int V_TOTAL_MAX = 1220,
    parameter bit SYNC_EN     = 1'b1,
    parameter int H_FP        = 16,
    parameter int H_SW        = 16,
    parameter int V_FP        = 2,
    parameter int V_SW        = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TOT_W-1:0]            h_total_in,
    input  logic [TOT_W-1:0]            v_total_in,
    output logic                        de,
    output logic                        hsync,
    output logic                        vsync,
    output logic [$clog2(H_ACTIVE)-1:0] x_pair,
    output logic [$clog2(V_ACTIVE)-1:0] y_line,
    output logic                        frame_start,
    output logic                        pwm_out
);
    localparam int HW = $clog2(H_TOTAL_MAX + 1);
    localparam int VW = $clog2(V_TOTAL_MAX + 1);
    localparam int XW = $clog2(H_ACTIVE);
    localparam int YW = $clog2(V_ACTIVE);

    logic [HW-1:0] h_tot;
    logic [VW-1:0] v_tot;
    logic          run;
    logic          frame_end;

    dpt_total_latch #(
        .TOT_W(TOT_W), .H_TOTAL_MIN(H_TOTAL_MIN), .H_TOTAL_MAX(H_TOTAL_MAX),
        .V_TOTAL_MIN(V_TOTAL_MIN), .V_TOTAL_MAX(V_TOTAL_MAX), .HW(HW), .VW(VW)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .h_req(h_total_in), .v_req(v_total_in),
        .h_tot(h_tot), .v_tot(v_tot)
    );

    dpt_raster #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .HW(HW), .VW(VW),
        .XW(XW), .YW(YW), .SYNC_EN(SYNC_EN),
        .H_FP(H_FP), .H_SW(H_SW), .V_FP(V_FP), .V_SW(V_SW)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .h_tot(h_tot), .v_tot(v_tot),
        .run(run), .frame_end(frame_end), .frame_start(frame_start),
        .de(de), .x_pair(x_pair), .y_line(y_line),
        .hsync(hsync), .vsync(vsync)
    );

    dpt_pwm_ref #(
        .HW(HW), .VW(VW)
    ) u_pwm (
        .clk(clk), .rst_n(rst_n), .run(run), .frame_end(frame_end),
        .h_tot(h_tot), .v_tot(v_tot), .pwm(pwm_out)
    );

    // R11: the reference is high on every frame start clock.
    assert_pwm_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> pwm_out);

    // R1: nothing is driven while reset is held.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (!de && !frame_start && !pwm_out)));

endmodule

// File: tb/sim_dual_pixel_timing_gen.sv
`timescale 1ns/1ps
module sim_dual_pixel_timing_gen;
    localparam int TOT_W = 12;
    localparam int HA = 8;
    localparam int VA = 4;
    localparam int HMIN = 12;
    localparam int HMAX = 20;
    localparam int VMIN = 6;
    localparam int VMAX = 9;
    localparam int HFP = 1;
    localparam int HSW = 2;
    localparam int VFP = 1;
    localparam int VSW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TOT_W-1:0] h_in = 12'd12;
    logic [TOT_W-1:0] v_in = 12'd6;

    logic de0, hs0, vs0, fs0, pwm0;
    logic [$clog2(HA)-1:0] x0;
    logic [$clog2(VA)-1:0] y0;
    logic de1, hs1, vs1, fs1, pwm1;
    logic [$clog2(HA)-1:0] x1;
    logic [$clog2(VA)-1:0] y1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_pixel_timing_gen #(
        .TOT_W(TOT_W), .H_ACTIVE(HA), .V_ACTIVE(VA),
        .H_TOTAL_MIN(HMIN), .H_TOTAL_MAX(HMAX),
        .V_TOTAL_MIN(VMIN), .V_TOTAL_MAX(VMAX), .SYNC_EN(1'b1),
        .H_FP(HFP), .H_SW(HSW), .V_FP(VFP), .V_SW(VSW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .h_total_in(h_in), .v_total_in(v_in),
        .de(de0), .hsync(hs0), .vsync(vs0), .x_pair(x0), .y_line(y0),
        .frame_start(fs0), .pwm_out(pwm0)
    );

    dual_pixel_timing_gen #(
        .TOT_W(TOT_W), .H_ACTIVE(HA), .V_ACTIVE(VA),
        .H_TOTAL_MIN(HMIN), .H_TOTAL_MAX(HMAX),
        .V_TOTAL_MIN(VMIN), .V_TOTAL_MAX(VMAX), .SYNC_EN(1'b0),
        .H_FP(HFP), .H_SW(HSW), .V_FP(VFP), .V_SW(VSW)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .h_total_in(h_in), .v_total_in(v_in),
        .de(de1), .hsync(hs1), .vsync(vs1), .x_pair(x1), .y_line(y1),
        .frame_start(fs1), .pwm_out(pwm1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scan one frame from its frame-start clock; lreq tags the length check.
    task automatic scan_frame(input int eh, input int ev, input string lreq,
                              input string tag);
        int bad_de = 0, bad_xy = 0, bad_fs = 0, bad_sync = 0, bad_ds = 0, bad_pwm = 0;
        int rises = 0;
        int pwm_c0 = 0;
        bit prev = 1'b0;
        int per = (eh * ev) / 3;
        for (int c = 0; c < eh * ev; c++) begin
            int h = c % eh;
            int v = c / eh;
            int ph = (c / per > 2) ? 2 : c / per;
            int pos = c - ph * per;
            bit e_de = (h < HA) && (v < VA);
            bit e_pwm = pos < per / 2;
            bit e_hs = (h >= HA + HFP) && (h < HA + HFP + HSW);
            bit e_vs = (v >= VA + VFP) && (v < VA + VFP + VSW);
            if (de0 !== e_de) bad_de++;
            if (e_de && (int'(x0) != h || int'(y0) != v)) bad_xy++;
            if (!e_de && (x0 != '0 || y0 != '0)) bad_xy++;
            if (fs0 !== (c == 0)) bad_fs++;
            if (hs0 !== e_hs || vs0 !== e_vs) bad_sync++;
            if (hs1 !== 1'b0 || vs1 !== 1'b0 || de1 !== de0 || x1 !== x0 || y1 !== y0)
                bad_ds++;
            if (pwm0 !== e_pwm) bad_pwm++;
            if (c == 0) pwm_c0 = int'(pwm0);
            if (pwm0 && (c == 0 || !prev)) rises++;
            prev = pwm0;
            @(negedge clk);
        end
        check(bad_de == 0, "R2", {"de mismatches ", tag}, bad_de, 0);
        check(bad_xy == 0, "R3", {"coordinate mismatches ", tag}, bad_xy, 0);
        check(bad_fs == 0, "R4", {"frame_start mismatches ", tag}, bad_fs, 0);
        check(fs0 === 1'b1, lreq, {"frame length, next start ", tag}, int'(fs0), 1);
        check(bad_sync == 0, "R8", {"sync mismatches ", tag}, bad_sync, 0);
        check(bad_ds == 0, "R9", {"no-sync instance mismatches ", tag}, bad_ds, 0);
        check(bad_pwm == 0, "R10", {"pwm clock mismatches ", tag}, bad_pwm, 0);
        check(rises == 3, "R10", {"pwm rising edges ", tag}, rises, 3);
        check(pwm_c0 == 1, "R11", {"pwm at frame start ", tag}, pwm_c0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(de0 === 1'b0 && fs0 === 1'b0 && pwm0 === 1'b0, "R1", "de/fs/pwm in reset",
              int'({de0, fs0, pwm0}), 0);
        check(hs0 === 1'b0 && vs0 === 1'b0 && x0 == '0 && y0 == '0, "R1",
              "sync/coords in reset", int'({hs0, vs0}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fs0 === 1'b1, "R1", "frame start on first clock after reset", int'(fs0), 1);
    endtask

    task automatic t_typical();
        scan_frame(12, 6, "R4", "typical 12x6");
    endtask

    task automatic t_midframe_change();
        h_in = 12'd14; v_in = 12'd7;
        scan_frame(12, 6, "R5", "old totals kept");
        scan_frame(14, 7, "R5", "new totals 14x7, remainder 2");
    endtask

    task automatic t_odd_line();
        h_in = 12'd13; v_in = 12'd8;
        scan_frame(14, 7, "R5", "before odd request");
        scan_frame(12, 8, "R6", "odd 13 -> 12");
    endtask

    task automatic t_below_min();
        h_in = 12'd4; v_in = 12'd2;
        scan_frame(12, 8, "R5", "before low request");
        scan_frame(12, 6, "R7", "low request -> 12x6");
    endtask

    task automatic t_above_max();
        h_in = 12'd30; v_in = 12'd20;
        scan_frame(12, 6, "R5", "before high request");
        scan_frame(20, 9, "R7", "high request -> 20x9");
        h_in = 12'd19; v_in = 12'd9;
        scan_frame(20, 9, "R5", "before 19");
        scan_frame(18, 9, "R6", "odd 19 -> 18");
    endtask

    initial begin
        t_reset();
        t_typical();
        t_midframe_change();
        t_odd_line();
        t_below_min();
        t_above_max();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule